// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits in front of a flow-through synchronous burst SRAM array. On every rising clock edge it samples the chip enables, the two address strobes, the advance input and the write controls. From these it classifies the coming cycle as deselect, burst start (read or write), burst continue, or burst suspend. It then drives three things for the array during that cycle: the current burst address, the per-byte write strobes, and the enable for the read-data output drivers.

One strobe is the processor strobe. A burst it starts is always a read, and the primary chip enable masks it. The other strobe is the controller strobe. A burst it starts is a read or a write, as the write controls decide. The two secondary chip enables are only looked at on strobe cycles. A two-bit burst offset steps through four beats, in linear order or interleaved order as `burst_order` selects.

The state machine has seven states. Its `cyc_kind` encoding is: IDLE_DESEL = 0, RD_START = 1, WR_START = 2, RD_NEXT = 3, WR_NEXT = 4, RD_HOLD = 5, WR_HOLD = 6. The transitions are checked in the order below:
- **Mask**: processor strobe low while the primary enable is high → IDLE_DESEL.
- **Start**: any strobe low, and all three enables active → RD_START or WR_START.
- **Refuse**: any strobe low, but an enable inactive → IDLE_DESEL.
- **Advance**: no strobe, device selected, advance low → RD_NEXT or WR_NEXT.
- **Pause**: no strobe, device selected, advance high → RD_HOLD or WR_HOLD.
- **Stay**: no strobe while in IDLE_DESEL → IDLE_DESEL.

Top module: `sbc_burst_ctl`

## Requirements
- R1: While reset is active and after its release with no strobe, `cyc_kind` is 0 (IDLE_DESEL), `byte_we` is 0 and `drive_en` is 0.
- R2: A cycle with `strb_p_n` low and `ce_n` high is a deselect (`cyc_kind` 0, `byte_we` 0), whatever the other inputs show.
- R3: On a strobe cycle, `sel_hi` low or `sel_lo_n` high deselects the device. On non-strobe cycles both are ignored.
- R4: A cycle with `strb_p_n` low and all three enables active starts a read (`cyc_kind` 1, `byte_we` 0), even with the write controls asserted. `mem_addr` equals the sampled `addr`.
- R5: A cycle with `strb_p_n` high, `strb_c_n` low and all enables active starts a burst at the sampled `addr`. It is a write (`cyc_kind` 2) when any write strobe is requested, and a read (`cyc_kind` 1) otherwise.
- R6: With `gw_n` low, a write cycle asserts all bits of `byte_we`.
- R7: With `gw_n` high and `bwe_n` low, `byte_we[i]` is the inverse of `lane_n[i]` (lane i is byte i of the word). If all `lane_n` bits are high, the cycle is a read.
- R8: With `gw_n` and `bwe_n` both high, the cycle is a read and `byte_we` is 0.
- R9: `drive_en` is 1 only in read states (1, 3, 5), and only while `oe_n` is low. It follows `oe_n` within the cycle, and it is 0 in write and deselect states.
- R10: A deselect stays in force through following non-strobe cycles, whatever `adv_n` shows, until a strobe cycle selects the device again.
- R11: A non-strobe cycle with `adv_n` low while selected advances the two-bit burst offset n. The low address bits become base+n mod 4 when `burst_order` is 0, and base XOR n when it is 1. The upper address bits do not change, and the sequence wraps after four beats.
- R12: A non-strobe cycle with `adv_n` high while selected keeps `mem_addr` unchanged.
- R13: The write strobes of each cycle come only from the lane enables sampled at that cycle's edge, so each continue beat of a write burst uses its own lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Primary chip enable, active low |
| sel_hi | input | 1 | Secondary chip enable, active high |
| sel_lo_n | input | 1 | Secondary chip enable, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-byte lane enables, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved burst order |
| addr | input | ADDR_W | External word address |
| cyc_kind | output | 3 | Current cycle state code |
| mem_addr | output | ADDR_W | Array address for the current cycle |
| byte_we | output | LANES | Per-byte write strobes for the array |
| drive_en | output | 1 | Enable for the read-data output drivers |

## Verification
The bound checker watches every cycle for several rules:
- the masking of the processor strobe;
- deselection by an inactive secondary enable on strobe cycles;
- the read-only start from the processor strobe and the loading of `mem_addr`;
- the all-lane global write and the per-lane byte write;
- the read fallback when both write controls are off;
- the legality of `drive_en`;
- deselect latching;
- the linear offset step and the suspend hold.

The interleaved sequence over a full four-beat wrap, and the ignoring of the secondary enables during continues, are shown only by bench scenarios. So is the end-to-end effect of the byte strobes on a behavioural array, read back through flow-through data.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        IDLE_DESEL = 3'd0,
        RD_START   = 3'd1,
        WR_START   = 3'd2,
        RD_NEXT    = 3'd3,
        WR_NEXT    = 3'd4,
        RD_HOLD    = 3'd5,
        WR_HOLD    = 3'd6
    } cyc_e;

    function automatic logic cyc_is_read(cyc_e c);
        return (c == RD_START) || (c == RD_NEXT) || (c == RD_HOLD);
    endfunction

    function automatic logic cyc_is_write(cyc_e c);
        return (c == WR_START) || (c == WR_NEXT) || (c == WR_HOLD);
    endfunction

endpackage

// File: rtl/sbc_lane_decode.sv
module sbc_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_req,
    output logic             any_wr
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_req[i] = !gw_n || (!bwe_n && !lane_n[i]);
    end

    assign any_wr = |lane_req;
endmodule

// File: rtl/sbc_cycle_decode.sv
module sbc_cycle_decode
    import sbc_pkg::*;
(
    input  cyc_e cur,
    input  logic ce_n,
    input  logic sel_hi,
    input  logic sel_lo_n,
    input  logic strb_p_n,
    input  logic strb_c_n,
    input  logic adv_n,
    input  logic any_wr,
    output cyc_e nxt,
    output logic load_addr,
    output logic step_beat
);
    logic strobe_hit;
    logic sel_ok;

    always_comb begin
        strobe_hit = !strb_p_n || !strb_c_n;
        sel_ok     = !ce_n && sel_hi && !sel_lo_n;
        nxt        = cur;
        load_addr  = 1'b0;
        step_beat  = 1'b0;
        if (!strb_p_n && ce_n) begin
            nxt = IDLE_DESEL;
        end else if (strobe_hit) begin
            if (!sel_ok) begin
                nxt = IDLE_DESEL;
            end else begin
                load_addr = 1'b1;
                if (!strb_p_n) nxt = RD_START;
                else           nxt = any_wr ? WR_START : RD_START;
            end
        end else begin
            unique case (cur)
                IDLE_DESEL: nxt = IDLE_DESEL;
                RD_START, WR_START, RD_NEXT, WR_NEXT, RD_HOLD, WR_HOLD: begin
                    if (!adv_n) begin
                        step_beat = 1'b1;
                        nxt = any_wr ? WR_NEXT : RD_NEXT;
                    end else begin
                        nxt = any_wr ? WR_HOLD : RD_HOLD;
                    end
                end
                default: nxt = IDLE_DESEL;
            endcase
        end
    end
endmodule

// File: rtl/sbc_burst_addr.sv
module sbc_burst_addr #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              step_beat,
    input  logic              burst_order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_addr) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step_beat) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        if (burst_order) lo_bits = base_q[BEAT_W-1:0] ^ beat_q;
        else             lo_bits = base_q[BEAT_W-1:0] + beat_q;
    end

    assign mem_addr = {base_q[ADDR_W-1 -: UP_W], lo_bits};
endmodule

// File: rtl/sbc_burst_ctl.sv
module sbc_burst_ctl
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              strb_p_n,
    input  logic              strb_c_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic              burst_order,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  byte_we,
    output logic              drive_en
);
    localparam int BEAT_W = 2;

    cyc_e             state_q;
    cyc_e             state_d;
    logic [LANES-1:0] lane_req;
    logic             any_wr;
    logic             load_addr;
    logic             step_beat;
    logic [LANES-1:0] lanes_q;

    sbc_lane_decode #(.LANES(LANES)) u_lanes (
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .lane_n   (lane_n),
        .lane_req (lane_req),
        .any_wr   (any_wr)
    );

    sbc_cycle_decode u_dec (
        .cur       (state_q),
        .ce_n      (ce_n),
        .sel_hi    (sel_hi),
        .sel_lo_n  (sel_lo_n),
        .strb_p_n  (strb_p_n),
        .strb_c_n  (strb_c_n),
        .adv_n     (adv_n),
        .any_wr    (any_wr),
        .nxt       (state_d),
        .load_addr (load_addr),
        .step_beat (step_beat)
    );

    sbc_burst_addr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_addr   (load_addr),
        .step_beat   (step_beat),
        .burst_order (burst_order),
        .addr_in     (addr),
        .mem_addr    (mem_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE_DESEL;
            lanes_q <= '0;
        end else begin
            state_q <= state_d;
            lanes_q <= cyc_is_write(state_d) ? lane_req : '0;
        end
    end

    // Outputs
    always_comb begin
        cyc_kind = state_q;
        byte_we  = cyc_is_write(state_q) ? lanes_q : '0;
        drive_en = cyc_is_read(state_q) && !oe_n;
    end
endmodule

// File: rtl/sbc_burst_ctl_chk.sv
module sbc_burst_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              strb_p_n,
    input logic              strb_c_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic [LANES-1:0]  lane_n,
    input logic              oe_n,
    input logic              burst_order,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        cyc_kind,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  byte_we,
    input logic              drive_en
);
    logic sel_ok;
    logic no_strobe;
    assign sel_ok    = !ce_n && sel_hi && !sel_lo_n;
    assign no_strobe = strb_p_n && strb_c_n;

    AST_MASK_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n && ce_n) |=> (cyc_kind == 3'd0 && byte_we == '0)); // R2
    AST_SEC_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_strobe && (!sel_hi || sel_lo_n)) |=> (cyc_kind == 3'd0)); // R3
    AST_P_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n && sel_ok) |=> (cyc_kind == 3'd1 && byte_we == '0 && mem_addr == $past(addr))); // R4
    AST_C_START: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n && !strb_c_n && sel_ok) |=> ((cyc_kind == 3'd1 || cyc_kind == 3'd2) && mem_addr == $past(addr))); // R5
    AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n && !strb_c_n && sel_ok && !gw_n) |=> (byte_we == '1)); // R6
    AST_LANE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 3'd0 && no_strobe && gw_n && !bwe_n) |=> (byte_we == ~$past(lane_n))); // R7
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n && !strb_c_n && sel_ok && gw_n && bwe_n) |=> (cyc_kind == 3'd1 && byte_we == '0)); // R8
    AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!oe_n && (cyc_kind == 3'd1 || cyc_kind == 3'd3 || cyc_kind == 3'd5))); // R9
    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 3'd0 && no_strobe) |=> (cyc_kind == 3'd0)); // R10
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 3'd0 && no_strobe && !adv_n && !burst_order) |=>
        (burst_order != $past(burst_order) ||
         (mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1) &&
          mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])))); // R11
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 3'd0 && no_strobe && adv_n) |=>
        (burst_order != $past(burst_order) || mem_addr == $past(mem_addr))); // R12
    AST_WR_CONT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 3'd0 && no_strobe && !adv_n && gw_n && !bwe_n && lane_n != '1) |=>
        (cyc_kind == 3'd4 && byte_we == ~$past(lane_n))); // R13
endmodule

bind sbc_burst_ctl sbc_burst_ctl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n), .burst_order(burst_order),
    .addr(addr), .cyc_kind(cyc_kind), .mem_addr(mem_addr), .byte_we(byte_we),
    .drive_en(drive_en)
);

// File: tb/sbc_burst_ctl_bench.sv
module sbc_burst_ctl_bench;
    localparam int AW = 16;
    localparam int LN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1, burst_order = 1'b0;
    logic [LN-1:0] lane_n = '1;
    logic [AW-1:0] addr = '0;
    logic [2:0]    cyc_kind;
    logic [AW-1:0] mem_addr;
    logic [LN-1:0] byte_we;
    logic          drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int            m_cyc = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic [LN-1:0] m_lanes = '0;
    logic [31:0]   din = '0;
    logic [31:0]   arr_dut [64];
    logic [31:0]   arr_mod [64];

    always #10 clk = ~clk;

    sbc_burst_ctl #(.ADDR_W(AW), .LANES(LN)) u_sbc_burst_ctl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .lane_n(lane_n), .oe_n(oe_n), .burst_order(burst_order),
        .addr(addr), .cyc_kind(cyc_kind), .mem_addr(mem_addr), .byte_we(byte_we),
        .drive_en(drive_en)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = burst_order ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic bit is_rd(int c);
        return c == 1 || c == 3 || c == 5;
    endfunction

    function automatic bit is_wr(int c);
        return c == 2 || c == 4 || c == 6;
    endfunction

    task automatic model_edge();
        logic [LN-1:0] req;
        bit wr, ok;
        req = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
        wr  = req != '0;
        ok  = !ce_n && sel_hi && !sel_lo_n;
        if (!strb_p_n && ce_n) m_cyc = 0;
        else if (!strb_p_n || !strb_c_n) begin
            if (!ok) m_cyc = 0;
            else begin
                m_base = addr; m_cnt = 2'd0;
                m_cyc = !strb_p_n ? 1 : (wr ? 2 : 1);
            end
        end else if (m_cyc != 0) begin
            if (!adv_n) begin m_cnt = m_cnt + 2'd1; m_cyc = wr ? 4 : 3; end
            else m_cyc = wr ? 6 : 5;
        end
        m_lanes = is_wr(m_cyc) ? req : '0;
    endtask

    function automatic string tag_of(int c);
        case (c)
            0: return "R10 deselect";
            1: return "R4 read start";
            2: return "R5 write start";
            3, 4: return "R11 continue";
            default: return "R12 suspend";
        endcase
    endfunction

    // one clock: inputs already applied at a falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag_of(m_cyc), 32'(cyc_kind), 32'(m_cyc));
        if (m_cyc != 0) chk("R11 address", 32'(mem_addr), 32'(exp_addr()));
        chk("R13 write strobes", 32'(byte_we), 32'(m_lanes));
        chk("R9 drive", 32'(drive_en), 32'(is_rd(m_cyc) && !oe_n));
        for (int b = 0; b < LN; b++) begin
            if (byte_we[b]) arr_dut[mem_addr[5:0]][8*b +: 8] = din[8*b +: 8];
            if (m_lanes[b]) arr_mod[exp_addr() & 16'h3F][8*b +: 8] = din[8*b +: 8];
        end
        if (drive_en && is_rd(m_cyc))
            chk("R9 read data", arr_dut[mem_addr[5:0]], arr_mod[exp_addr() & 16'h3F]);
    endtask

    task automatic put(bit pn, bit cn, bit av, bit g, bit bw, logic [LN-1:0] ln, bit oe, logic [AW-1:0] a);
        strb_p_n = pn; strb_c_n = cn; adv_n = av; gw_n = g; bwe_n = bw;
        lane_n = ln; oe_n = oe; addr = a; din = $urandom;
        tick();
    endtask

    initial begin
        void'($urandom(32'd7731));
        for (int i = 0; i < 64; i++) begin arr_dut[i] = '0; arr_mod[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 reset state", 32'(cyc_kind), 0);
        chk("R1 reset we", 32'(byte_we), 0);
        oe_n = 1'b0;
        #1;
        chk("R1 reset drive", 32'(drive_en), 0);
        rst_n = 1'b1;
        put(1, 1, 0, 1, 1, '1, 0, 16'h0);
        chk("R1 idle after reset", 32'(cyc_kind), 0);

        // linear burst from offset 2
        burst_order = 0;
        put(0, 1, 1, 0, 0, 4'h0, 0, 16'h1232);
        chk("R4 p strobe read despite gw", 32'(cyc_kind), 1);
        chk("R4 no write", 32'(byte_we), 0);
        chk("R4 address", 32'(mem_addr), 32'h1232);
        put(1, 1, 0, 1, 1, '1, 0, 16'h0); chk("R11 lin 1", 32'(mem_addr), 32'h1233);
        sel_hi = 0; sel_lo_n = 1;
        put(1, 1, 0, 1, 1, '1, 0, 16'h0); chk("R11 lin wrap", 32'(mem_addr), 32'h1230);
        chk("R3 secondaries ignored on continue", 32'(cyc_kind), 3);
        sel_hi = 1; sel_lo_n = 0;
        put(1, 1, 1, 1, 1, '1, 0, 16'h0); chk("R12 suspend", 32'(mem_addr), 32'h1230);
        put(1, 1, 0, 1, 1, '1, 0, 16'h0); chk("R11 lin 3", 32'(mem_addr), 32'h1231);

        // interleaved from offset 1, with writes
        burst_order = 1;
        put(1, 0, 1, 0, 1, '1, 1, 16'h00A1);
        chk("R6 all lanes", 32'(byte_we), 32'hF);
        chk("R5 c strobe write", 32'(cyc_kind), 2);
        chk("R9 no drive on write", 32'(drive_en), 0);
        put(1, 1, 0, 1, 0, 4'b1010, 1, 16'h0);
        chk("R11 ilv 1", 32'(mem_addr), 32'h00A0);
        chk("R7 lane pick", 32'(byte_we), 32'h5);
        put(1, 1, 0, 1, 0, 4'b0110, 1, 16'h0);
        chk("R11 ilv 2", 32'(mem_addr), 32'h00A3);
        chk("R13 own lanes", 32'(byte_we), 32'h9);
        put(1, 1, 0, 1, 0, 4'b1111, 0, 16'h0);
        chk("R11 ilv 3", 32'(mem_addr), 32'h00A2);
        chk("R7 all lanes off reads", 32'(cyc_kind), 3);
        put(1, 1, 0, 1, 1, 4'b0000, 0, 16'h0);
        chk("R11 ilv wrap", 32'(mem_addr), 32'h00A1);
        chk("R8 bwe off reads", 32'(cyc_kind), 3);
        chk("R9 drive on read", 32'(drive_en), 1);
        oe_n = 1; #1;
        chk("R9 oe high no drive", 32'(drive_en), 0);

        // masking and latched deselect
        ce_n = 1;
        put(0, 0, 0, 0, 0, 4'h0, 0, 16'h0044);
        chk("R2 masked", 32'(cyc_kind), 0);
        ce_n = 0;
        put(1, 1, 0, 0, 0, 4'h0, 0, 16'h0);
        chk("R10 stays deselected", 32'(cyc_kind), 0);
        chk("R10 no write", 32'(byte_we), 0);
        sel_hi = 0;
        put(1, 0, 1, 1, 1, '1, 0, 16'h0050);
        chk("R3 secondary deselects", 32'(cyc_kind), 0);
        sel_hi = 1;
        put(1, 0, 1, 1, 1, '1, 0, 16'h0050);
        chk("R8 c strobe read", 32'(cyc_kind), 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            ce_n     = ($urandom % 8) == 0;
            sel_hi   = ($urandom % 10) != 0;
            sel_lo_n = ($urandom % 10) == 0;
            if ((i % 200) == 0) burst_order = $urandom % 2;
            put(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % 2,
                ($urandom % 4) != 0, $urandom % 2, 4'($urandom),
                $urandom % 2, 16'($urandom % 64));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule